// File: doc/BRIEF.md
# Brightness-Adaptive Dual-Channel Ramp Stepper

This block moves two brightness values toward their targets, one ramp tick at a time. The primary value is 15 bits wide and the secondary value is 8 bits wide. On each tick the primary value takes more single-unit steps when it is bright and fewer when it is dim. This makes a ramp coarse near full brightness and fine near off. The secondary value always takes a fixed four steps per tick.

An accepted tick latches both targets. The block then applies one step per clock for as many clocks as the longer of the two step budgets. While that runs, busy is high. When it ends, done reports whether both values have arrived at their targets.

A move from fully off to full output, or from full output to off, skips the ramp and lands on the target in the clock of the tick. The logic that turns these values into PWM, and the timing of the tick strobe, belong to neighbouring blocks.

Top module: `ramp_stepper`

## Requirements
- R1: While rst_ni is low, pri_o, sec_o, busy_o and done_o are all zero.
- R2: A single step changes a value by exactly one toward its latched target: +1 when below, -1 when above, and no change when equal. A value therefore never passes its target.
- R3: An accepted tick gives the primary value a budget of (p >> 9) + 1 steps, where p is pri_o in the clock the tick is accepted. With the 15-bit default, this budget runs from 1 to 64.
- R4: An accepted tick gives the secondary value a budget of 4 steps.
- R5: The tick jumps at once in two cases. If pri_o equals the maximum level (default 32640) and the primary target is 0, or if pri_o is 0 and the target is the maximum level, then pri_o equals the target on the clock after the tick. No ramp is applied.
- R6: After an accepted tick, busy_o is high for exactly max(primary budget, 4) clocks, with one step of each unfinished budget applied per clock.
- R7: done_o changes only in the clock in which busy_o falls. It is then 1 exactly when pri_o and sec_o equal the targets latched at the tick.
- R8: A tick is accepted only while busy_o is low. A tick, or a target change, while busy_o is high has no effect on the running ramp.
- R9: While idle with no tick, pri_o and sec_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Ramp tick strobe |
| pri_tgt_i | input | 15 | Primary target level |
| sec_tgt_i | input | 8 | Secondary target level |
| pri_o | output | 15 | Current primary level |
| sec_o | output | 8 | Current secondary level |
| busy_o | output | 1 | Steps of the current tick remain |
| done_o | output | 1 | Both values were at their targets when the last tick ended |

## Verification
The assertions take the targets latched inside the block as the reference for the done check, so they hold even when the input targets move during a ramp. The unit-step properties assume the primary value only jumps in the clock a tick is accepted, never while busy. The stimulus changes the targets and raises tick_i only on the falling clock edge. It deliberately drives a tick and a new target in the middle of a ramp, to show that both are ignored.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } step_dir_e;
endpackage

// File: rtl/ramp_step_count.sv
module ramp_step_count #(
  parameter int W     = 15,
  parameter int SHIFT = 9,
  parameter int CW    = W - SHIFT + 1
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] cnt_o
);
  // brighter start value -> more unit steps this tick
  always_comb cnt_o = CW'(val_i >> SHIFT) + CW'(1);
endmodule

// File: rtl/ramp_lane.sv
module ramp_lane
  import ramp_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          force_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [W-1:0]  tgt_i,
  output logic [W-1:0]  val_o,
  output logic [W-1:0]  tgt_o,
  output logic [CW-1:0] left_o,
  output logic [W-1:0]  nxt_o
);
  logic [W-1:0]  val_q, tgt_q, stepped;
  logic [CW-1:0] left_q;
  step_dir_e     dir;

  always_comb begin
    if (val_q < tgt_q)      dir = DIR_UP;
    else if (val_q > tgt_q) dir = DIR_DOWN;
    else                    dir = DIR_HOLD;
  end

  always_comb begin
    unique case (dir)
      DIR_UP:   stepped = val_q + W'(1);
      DIR_DOWN: stepped = val_q - W'(1);
      default:  stepped = val_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      tgt_q  <= '0;
      left_q <= '0;
    end else if (start_i) begin
      tgt_q  <= tgt_i;
      left_q <= cnt_i;
      if (force_i) val_q <= tgt_i;
    end else if (left_q != '0) begin
      val_q  <= stepped;
      left_q <= left_q - CW'(1);
    end
  end

  assign val_o  = val_q;
  assign tgt_o  = tgt_q;
  assign left_o = left_q;
  assign nxt_o  = (left_q != '0) ? stepped : val_q;
endmodule

// File: rtl/ramp_stepper.sv
module ramp_stepper #(
  parameter int PRI_W     = 15,
  parameter int SEC_W     = 8,
  parameter int SHIFT     = 9,
  parameter int SEC_STEPS = 4,
  parameter int MAX_LVL   = 255 << 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [PRI_W-1:0] pri_tgt_i,
  input  logic [SEC_W-1:0] sec_tgt_i,
  output logic [PRI_W-1:0] pri_o,
  output logic [SEC_W-1:0] sec_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int CW = PRI_W - SHIFT + 1;
  localparam logic [PRI_W-1:0] MAX_V = PRI_W'(MAX_LVL);

  logic             busy_q, done_q, accept, jump, finish;
  logic [CW-1:0]    pri_cnt, pri_left, sec_left;
  logic [PRI_W-1:0] pri_tgt_q, pri_nxt;
  logic [SEC_W-1:0] sec_tgt_q, sec_nxt;

  assign accept = tick_i && !busy_q;
  assign jump   = ((pri_o == MAX_V) && (pri_tgt_i == '0)) ||
                  ((pri_o == '0) && (pri_tgt_i == MAX_V));
  assign finish = busy_q && (pri_left <= CW'(1)) && (sec_left <= CW'(1));

  ramp_step_count #(.W(PRI_W), .SHIFT(SHIFT), .CW(CW)) u_cnt (
    .val_i (pri_o),
    .cnt_o (pri_cnt)
  );

  ramp_lane #(.W(PRI_W), .CW(CW)) u_pri (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .force_i (jump),
    .cnt_i   (pri_cnt),
    .tgt_i   (pri_tgt_i),
    .val_o   (pri_o),
    .tgt_o   (pri_tgt_q),
    .left_o  (pri_left),
    .nxt_o   (pri_nxt)
  );

  ramp_lane #(.W(SEC_W), .CW(CW)) u_sec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .force_i (1'b0),
    .cnt_i   (CW'(SEC_STEPS)),
    .tgt_i   (sec_tgt_i),
    .val_o   (sec_o),
    .tgt_o   (sec_tgt_q),
    .left_o  (sec_left),
    .nxt_o   (sec_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
    end else if (finish) begin
      busy_q <= 1'b0;
      done_q <= (pri_nxt == pri_tgt_q) && (sec_nxt == sec_tgt_q);
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/ramp_stepper_chk.sv
module ramp_stepper_chk #(
  parameter int PRI_W   = 15,
  parameter int SEC_W   = 8,
  parameter int MAX_LVL = 255 << 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [PRI_W-1:0] pri_tgt_i,
  input logic [PRI_W-1:0] pri_o,
  input logic [SEC_W-1:0] sec_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [PRI_W-1:0] pri_tgt_q,
  input logic [SEC_W-1:0] sec_tgt_q
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (pri_o == '0 && sec_o == '0 && !busy_o && !done_o);
    end
  end

  a_r2_pri_unit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (pri_o == $past(pri_o) || pri_o == $past(pri_o) + 1 ||
                pri_o == $past(pri_o) - 1));

  a_r4_sec_unit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (sec_o == $past(sec_o) || sec_o == $past(sec_o) + 1 ||
                sec_o == $past(sec_o) - 1));

  a_r5_jump_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !busy_o && pri_o == PRI_W'(MAX_LVL) && pri_tgt_i == '0) |=> pri_o == '0);

  a_r6_busy_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !busy_o) |=> busy_o);

  a_r7_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || $stable(done_o)));

  a_r7_done_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o == ((pri_o == pri_tgt_q) && (sec_o == sec_tgt_q)));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !tick_i) |=> ($stable(pri_o) && $stable(sec_o) && $stable(done_o)));
endmodule

bind ramp_stepper ramp_stepper_chk #(.PRI_W(PRI_W), .SEC_W(SEC_W), .MAX_LVL(MAX_LVL)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .pri_tgt_i (pri_tgt_i),
  .pri_o     (pri_o),
  .sec_o     (sec_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .pri_tgt_q (pri_tgt_q),
  .sec_tgt_q (sec_tgt_q)
);

// File: tb/tb_ramp_stepper.sv
module tb_ramp_stepper;
  localparam int MAXL = 32640;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [14:0] pri_tgt = '0;
  logic [7:0]  sec_tgt = '0;
  logic [14:0] pri;
  logic [7:0]  sec;
  logic        busy, done;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  ramp_stepper dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pri_tgt_i(pri_tgt),
    .sec_tgt_i(sec_tgt), .pri_o(pri), .sec_o(sec), .busy_o(busy), .done_o(done)
  );

  // behavioural reference
  int m_pri, m_sec, m_tp, m_ts, m_pl, m_sl;
  bit m_busy, m_done;

  function automatic int toward(int v, int t);
    if (v < t) return v + 1;
    if (v > t) return v - 1;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pri = 0; m_sec = 0; m_busy = 0; m_done = 0; m_pl = 0; m_sl = 0; m_tp = 0; m_ts = 0;
    end else if (!m_busy && tick) begin
      m_tp = int'(pri_tgt); m_ts = int'(sec_tgt);
      m_pl = (m_pri / 512) + 1; m_sl = 4;
      if ((m_pri == MAXL && m_tp == 0) || (m_pri == 0 && m_tp == MAXL)) m_pri = m_tp;
      m_busy = 1;
    end else if (m_busy) begin
      if (m_pl > 0) begin m_pri = toward(m_pri, m_tp); m_pl--; end
      if (m_sl > 0) begin m_sec = toward(m_sec, m_ts); m_sl--; end
      if (m_pl == 0 && m_sl == 0) begin
        m_busy = 0;
        m_done = (m_pri == m_tp) && (m_sec == m_ts);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(pri) == m_pri, "R2/R3 model pri", int'(pri), m_pri);
      chk(int'(sec) == m_sec, "R4 model sec", int'(sec), m_sec);
      chk(busy == m_busy, "R6 model busy", int'(busy), int'(m_busy));
      chk(done == m_done, "R7 model done", int'(done), int'(m_done));
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  // call at a negedge; returns pri one clock after the tick and busy clock count
  task automatic do_tick(input int p, input int s, output int first, output int cyc);
    pri_tgt = 15'(p); sec_tgt = 8'(s); tick = 1'b1;
    @(negedge clk);
    tick = 1'b0; first = int'(pri); cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
  endtask

  initial begin
    int f, c;
    repeat (3) @(negedge clk);
    chk(pri == 0 && sec == 0 && !busy && !done, "R1 reset", int'(pri) + int'(sec) + int'(busy) + int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_tick(3, 10, f, c);
    chk(pri == 1, "R3 one step when dim", int'(pri), 1);
    chk(sec == 4, "R4 four secondary steps", int'(sec), 4);
    chk(c == 4, "R6 busy length four", c, 4);
    chk(!done, "R7 not arrived", int'(done), 0);
    do_tick(3, 10, f, c);
    do_tick(3, 10, f, c);
    chk(pri == 3 && sec == 10, "R2 hold at target", int'(pri) * 100 + int'(sec), 310);
    chk(done, "R7 arrived", int'(done), 1);
    repeat (5) @(negedge clk);
    chk(pri == 3 && sec == 10, "R9 idle hold", int'(pri) * 100 + int'(sec), 310);

    for (int i = 0; i < 3; i++) do_tick(0, 10, f, c);
    chk(pri == 0, "R2 down to zero", int'(pri), 0);

    do_tick(MAXL, 10, f, c);
    chk(f == MAXL, "R5 jump up", f, MAXL);
    chk(c == 4, "R6 jump busy length", c, 4);
    chk(done, "R7 done after jump", int'(done), 1);

    do_tick(32000, 10, f, c);
    chk(pri == 32576, "R3 64 steps when bright", int'(pri), 32576);
    chk(c == 64, "R6 busy length 64", c, 64);
    chk(!done, "R7 not arrived bright", int'(done), 0);

    // R8: tick and target change during a ramp
    pri_tgt = 15'd32000; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0; c = 0;
    repeat (5) begin c++; @(negedge clk); end
    pri_tgt = 15'd0; tick = 1'b1;
    @(negedge clk);
    c++; tick = 1'b0;
    while (busy) begin c++; @(negedge clk); end
    chk(pri == 32512, "R8 busy tick ignored", int'(pri), 32512);
    chk(c == 64, "R8 ramp length kept", c, 64);

    do_tick(32513, 10, f, c);
    chk(pri == 32513, "R2 no overshoot", int'(pri), 32513);
    chk(done, "R7 arrived high", int'(done), 1);
    do_tick(MAXL, 10, f, c);
    do_tick(MAXL, 10, f, c);
    chk(pri == MAXL, "R2 reach max", int'(pri), MAXL);
    do_tick(0, 10, f, c);
    chk(f == 0, "R5 jump down", f, 0);
    chk(c == 64, "R3 budget from start value", c, 64);
    chk(done, "R7 done after jump down", int'(done), 1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule